// File: doc/BRIEF.md
# Prioritized Interrupt Identification Unit

This block sits inside a 16550-style serial controller and decides which one of four interrupt causes is reported to software at any moment. It takes the four cause-enable bits, the receiver overrun flag, a receive-buffer non-empty flag, the modem-status change nibble and the FIFO-mode bit. From these it forms the identification byte that a read of the interrupt identification register returns, and it drives a level interrupt request.

The only state it keeps is a sticky "transmitter empty" pending flag. Every write to the transmit data register sets this flag. The flag clears only when an identification read happens while the reported cause is transmitter empty. All other outputs follow their inputs combinationally, so the request line is re-evaluated as soon as any register access or receive-side update changes an input.

Top module: `irq_ident`

## Requirements
- R1: After a synchronous active-low reset the transmitter-empty pending flag is clear. With only the transmit enable set, the reason field reads 0x1 and `irq` is low.
- R2: When `ovr_flag` and `en_line` are both set, the reason field is 0x6, whatever the other causes are.
- R3: When no line-status cause is active and `rx_nonempty` and `en_rx` are both set, the reason field is 0xC, the timeout code.
- R4: When the pending flag and `en_tx` are both set and no higher cause is active, the reason field is 0x2. This cause outranks the modem cause.
- R5: When any bit of `msr_delta` is set, `en_modem` is set and no higher cause is active, the reason field is 0x0.
- R6: When no enabled cause is active, the reason field is 0x1.
- R7: A `data_wr` pulse sets the pending flag, and it is visible from the next clock cycle.
- R8: An `iir_rd` pulse in a cycle whose reported reason is 0x2 clears the pending flag from the next cycle, unless `data_wr` is also high in that cycle.
- R9: An `iir_rd` pulse in a cycle that reports any other reason leaves the pending flag unchanged.
- R10: `iir_value[7:6]` is 2'b11 when `fifo_mode` is set and 2'b00 otherwise. `iir_value[5:4]` is always zero and `iir_value[3:0]` holds the reason.
- R11: `irq` is high exactly when the reason field differs from 0x1. This includes the modem reason 0x0.
- R12: A cause whose enable bit is clear has no effect on the reason or on `irq`.
- R13: When `data_wr` and `iir_rd` occur in the same cycle, the pending flag is set in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_rx | input | 1 | Enable for the receive-data cause |
| en_tx | input | 1 | Enable for the transmitter-empty cause |
| en_line | input | 1 | Enable for the line-status cause |
| en_modem | input | 1 | Enable for the modem-status cause |
| ovr_flag | input | 1 | Receiver overrun flag |
| rx_nonempty | input | 1 | Receive buffer holds at least one character |
| msr_delta | input | 4 | Modem-status change bits |
| fifo_mode | input | 1 | FIFO mode is enabled |
| data_wr | input | 1 | One-cycle pulse: transmit data register written |
| iir_rd | input | 1 | One-cycle pulse: identification register read |
| iir_value | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request level |

## Verification
`iir_value` and `irq` respond to level inputs in the same cycle. The bench therefore samples them after the inputs settle and before the next rising edge. A `data_wr` or `iir_rd` pulse only takes effect after that edge, so the bench expects its result one cycle later, in the next driven step. The driver pushes one expected item for each step, and the monitor compares that item two nanoseconds after the step's falling edge. This keeps every sample inside the cycle it belongs to.

// File: rtl/irq_ident_pkg.sv
// Package: shared reason codes for the interrupt identification unit.
// Assumes a 4-bit reason field in the low bits of the identification byte.
package irq_ident_pkg;
    localparam int RSN_W = 4;

    typedef enum logic [RSN_W-1:0] {
        RSN_MODEM = 4'h0,
        RSN_NONE  = 4'h1,
        RSN_TXE   = 4'h2,
        RSN_LINE  = 4'h6,
        RSN_RXTO  = 4'hC
    } reason_t;
endpackage

// File: rtl/irq_ident_txpend.sv
// Module: sticky transmitter-empty pending flag.
// A data write sets the flag. A read that reports transmitter empty clears it.
// Set wins when both happen in the same cycle. Assumes single-cycle pulses.
module irq_ident_txpend (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pulse,
    input  logic clr_pulse,
    output logic pend
);
    // Purpose: hold the pending flag across cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (set_pulse)
            pend <= 1'b1;
        else if (clr_pulse)
            pend <= 1'b0;
    end

    a_r7_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |=> pend);
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pulse && !set_pulse) |=> !pend);
    a_r13_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pulse && set_pulse) |=> pend);
endmodule

// File: rtl/irq_ident_prio.sv
// Module: fixed-priority selection of the reported interrupt reason.
// Order: line status, receive data, transmitter empty, modem status.
// Assumes the inputs are stable levels. The module is purely combinational,
// and the clock is only used by its checks.
module irq_ident_prio #(
    parameter int DELTA_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         en_rx,
    input  logic                         en_tx,
    input  logic                         en_line,
    input  logic                         en_modem,
    input  logic                         ovr_flag,
    input  logic                         rx_nonempty,
    input  logic                         tx_pend,
    input  logic [DELTA_W-1:0]           msr_delta,
    output irq_ident_pkg::reason_t       reason
);
    import irq_ident_pkg::*;

    logic line_hit, rx_hit, tx_hit, modem_hit;

    // Purpose: qualify each cause with its enable bit.
    always_comb begin
        line_hit  = ovr_flag && en_line;
        rx_hit    = rx_nonempty && en_rx;
        tx_hit    = tx_pend && en_tx;
        modem_hit = (|msr_delta) && en_modem;
    end

    // Purpose: pick the highest-priority qualified cause.
    always_comb begin
        if (line_hit)       reason = RSN_LINE;
        else if (rx_hit)    reason = RSN_RXTO;
        else if (tx_hit)    reason = RSN_TXE;
        else if (modem_hit) reason = RSN_MODEM;
        else                reason = RSN_NONE;
    end

    a_r2_line_first: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && en_line) |-> (reason == RSN_LINE));
    a_r12_masked_none: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_rx && !en_tx && !en_line && !en_modem) |-> (reason == RSN_NONE));
endmodule

// File: rtl/irq_ident_fmt.sv
// Module: forms the identification byte and the request level from the reason.
// Assumes the reason occupies the low bits and the FIFO indicator the top two.
module irq_ident_fmt (
    input  logic                   fifo_mode,
    input  irq_ident_pkg::reason_t reason,
    output logic [7:0]             iir_value,
    output logic                   irq
);
    import irq_ident_pkg::*;

    localparam int PAD_W = 8 - 2 - RSN_W;

    // Purpose: assemble the byte and derive the request line.
    always_comb begin
        iir_value = {{2{fifo_mode}}, {PAD_W{1'b0}}, reason};
        irq       = (reason != RSN_NONE);
    end
endmodule

// File: rtl/irq_ident.sv
// Module: top of the interrupt identification unit.
// Connects the pending flag, the priority selector and the byte formatter.
// Assumes data_wr and iir_rd are single-cycle pulses in the clk domain.
module irq_ident #(
    parameter int DELTA_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_rx,
    input  logic               en_tx,
    input  logic               en_line,
    input  logic               en_modem,
    input  logic               ovr_flag,
    input  logic               rx_nonempty,
    input  logic [DELTA_W-1:0] msr_delta,
    input  logic               fifo_mode,
    input  logic               data_wr,
    input  logic               iir_rd,
    output logic [7:0]         iir_value,
    output logic               irq
);
    import irq_ident_pkg::*;

    logic    tx_pend;
    logic    rd_clear;
    reason_t reason;

    // Purpose: a read clears the flag only when it reports transmitter empty.
    always_comb rd_clear = iir_rd && (reason == RSN_TXE);

    irq_ident_txpend u_txpend (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (data_wr),
        .clr_pulse (rd_clear),
        .pend      (tx_pend)
    );

    irq_ident_prio #(.DELTA_W(DELTA_W)) u_prio (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_rx       (en_rx),
        .en_tx       (en_tx),
        .en_line     (en_line),
        .en_modem    (en_modem),
        .ovr_flag    (ovr_flag),
        .rx_nonempty (rx_nonempty),
        .tx_pend     (tx_pend),
        .msr_delta   (msr_delta),
        .reason      (reason)
    );

    irq_ident_fmt u_fmt (
        .fifo_mode (fifo_mode),
        .reason    (reason),
        .iir_value (iir_value),
        .irq       (irq)
    );

    a_r11_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (iir_value[3:0] != 4'h1));
    a_r10_fifo_bits: assert property (@(posedge clk) disable iff (!rst_n)
        iir_value[7:4] == {fifo_mode, fifo_mode, 2'b00});
    a_r9_other_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && reason != RSN_TXE && tx_pend) |=> tx_pend);
endmodule

// File: tb/irq_ident_bench.sv
module irq_ident_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_rx = 0, en_tx = 0, en_line = 0, en_modem = 0;
    logic       ovr_flag = 0, rx_nonempty = 0, fifo_mode = 0;
    logic [3:0] msr_delta = 4'h0;
    logic       data_wr = 0, iir_rd = 0;
    logic [7:0] iir_value;
    logic       irq;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] iir;
        logic       irq;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    event pushed;

    irq_ident u_irq_ident (
        .clk(clk), .rst_n(rst_n), .en_rx(en_rx), .en_tx(en_tx),
        .en_line(en_line), .en_modem(en_modem), .ovr_flag(ovr_flag),
        .rx_nonempty(rx_nonempty), .msr_delta(msr_delta),
        .fifo_mode(fifo_mode), .data_wr(data_wr), .iir_rd(iir_rd),
        .iir_value(iir_value), .irq(irq)
    );

    always #5 clk = ~clk;

    // Driver: set the inputs at the falling edge and push the expected item.
    task automatic step(input logic [3:0] en, input logic ovr, input logic rxne,
                        input logic [3:0] dlt, input logic fm, input logic wr,
                        input logic rd, input logic [7:0] e_iir, input string tag);
        exp_t it;
        @(negedge clk);
        {en_line, en_rx, en_tx, en_modem} = en;
        ovr_flag = ovr; rx_nonempty = rxne; msr_delta = dlt;
        fifo_mode = fm; data_wr = wr; iir_rd = rd;
        it.iir = e_iir;
        it.irq = (e_iir[3:0] != 4'h1);
        it.tag = tag;
        exp_q.push_back(it);
        -> pushed;
    endtask

    // Monitor: compare two nanoseconds after each pushed step.
    initial begin
        forever begin
            @(pushed);
            #2;
            while (exp_q.size() > 0) begin
                exp_t it;
                it = exp_q.pop_front();
                tests++;
                if (iir_value !== it.iir || irq !== it.irq) begin
                    fails++;
                    $display("FAIL %s: iir=%h irq=%b expected iir=%h irq=%b",
                             it.tag, iir_value, irq, it.iir, it.irq);
                end
            end
        end
    end

    // Enable order in step(): {line, rx, tx, modem}.
    initial begin
        repeat (3) @(negedge clk);
        step(4'b0010, 0, 0, 4'h0, 0, 0, 0, 8'h01, "R1 reset state");
        rst_n = 1'b1;
        step(4'b0010, 0, 0, 4'h0, 0, 0, 0, 8'h01, "R1 flag clear after reset");
        step(4'b1111, 1, 1, 4'hF, 0, 0, 0, 8'h06, "R2 line highest");
        step(4'b1111, 1, 1, 4'hF, 1, 0, 0, 8'hC6, "R10 fifo bits");
        step(4'b0111, 1, 1, 4'hF, 0, 0, 0, 8'h0C, "R3 rx timeout code, R12 line masked");
        step(4'b0010, 1, 1, 4'hF, 0, 1, 0, 8'h01, "R12 masked causes, R6 none");
        step(4'b0010, 0, 0, 4'h0, 0, 0, 0, 8'h02, "R7 write sets flag");
        step(4'b0010, 0, 0, 4'h0, 1, 0, 0, 8'hC2, "R10 fifo with tx");
        step(4'b0110, 0, 1, 4'h0, 0, 0, 1, 8'h0C, "R3 rx over tx");
        step(4'b0010, 0, 0, 4'h0, 0, 0, 0, 8'h02, "R9 other read keeps flag");
        step(4'b0010, 0, 0, 4'h0, 0, 1, 1, 8'h02, "R13 write and read together");
        step(4'b0010, 0, 0, 4'h0, 0, 0, 0, 8'h02, "R13 flag still set");
        step(4'b0010, 0, 0, 4'h0, 0, 0, 1, 8'h02, "R8 read reporting tx");
        step(4'b0011, 0, 0, 4'h4, 0, 0, 0, 8'h00, "R8 flag cleared, R5 modem, R11 irq on code 0");
        step(4'b0010, 0, 0, 4'h0, 0, 0, 0, 8'h01, "R8 flag stays clear");
        step(4'b0000, 0, 0, 4'hF, 0, 1, 0, 8'h01, "R12 modem masked");
        step(4'b0001, 0, 0, 4'h1, 0, 0, 0, 8'h00, "R4 tx masked, modem shows");
        step(4'b0011, 0, 0, 4'h1, 0, 0, 0, 8'h02, "R4 tx over modem");
        step(4'b0000, 0, 0, 4'h0, 1, 0, 0, 8'hC1, "R6 none in fifo mode");
        @(negedge clk);
        data_wr = 0; iir_rd = 0;
        #3;
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #200000;
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule